// File: doc/BRIEF.md
# Chip-Select Framed SPI Slave with Readiness Status Byte

This block is a full-duplex SPI slave (mode 0, MSB first) whose sessions are framed by an active-low select. Each byte the master shifts in is answered by one byte shifted out. The select, serial clock and data-in pins are brought into the system clock domain and their edges are detected there, so the serial clock may run at any rate up to a fraction of the system clock and may stop at any point; a stopped clock simply holds all state.

At the start of every session the slave is in a status phase. Each outgoing byte is chosen when the previous byte ends or when the select falls. While the local `app_ready` input is low, the slave answers with a busy code. The first boundary that sees `app_ready` high sends an idle code once, and from then on application bytes are taken from `tx_data`, each acknowledged by a `tx_take` pulse. Neither code may be all ones, so a master can tell a present slave from an absent one whose line floats high. Raising the select ends the session at once, even mid-byte: both shift registers and the bit counter are cleared, so no fragment reaches the next session.

The MISO pad is tri-stated from outside using `spi_miso_oe`, which is high only while the synchronised select is low.

Top module: `spi_sts_slave`

## Requirements
- R1: `spi_miso_oe` goes low within 4 clocks after `spi_cs_n` rises and high within 4 clocks after it falls, and is never high while the select has been high for 4 or more clocks.
- R2: MOSI is sampled on SCLK rising edges, MSB first; after the 8th rising edge of a byte, `rx_valid` pulses for exactly one clock with the assembled byte on `rx_data`.
- R3: Each outgoing byte is shifted MSB first on `spi_miso_d`, which changes after SCLK falling edges; its first bit is present before the first rising edge of that byte.
- R4: While `app_ready` is low at a byte boundary in the status phase, the byte sent is the busy code (parameter, default 8'hA5); elaboration fails if either status code is all ones.
- R5: The first boundary in a session that sees `app_ready` high sends the idle code (parameter, default 8'h5A) once; every later byte of the session is the `tx_data` value present at the boundary, which `tx_take` acknowledges with a one-clock pulse.
- R6: Every new session begins in the status phase, so its first byte is the busy or the idle code even if the previous session was sending data.
- R7: Raising the select mid-byte produces no `rx_valid`, and the next session starts byte-aligned with no leftover receive or transmit bits.
- R8: Arbitrarily long pauses of SCLK inside a byte do not change the transferred bytes.
- R9: After reset, `spi_miso_oe`, `spi_miso_d`, `rx_valid` and `tx_take` are all 0.
- R10: `spi_miso_d` is 0 whenever the slave is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low select from master |
| spi_sclk | input | 1 | Serial clock from master (idle low) |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso_d | output | 1 | Serial data towards master |
| spi_miso_oe | output | 1 | Output enable for the MISO tri-state pad |
| app_ready | input | 1 | Local logic ready for data transfer |
| tx_data | input | BYTE_W | Next application byte to send |
| tx_take | output | 1 | One-clock pulse: `tx_data` loaded into the shifter |
| rx_data | output | BYTE_W | Last complete received byte |
| rx_valid | output | 1 | One-clock pulse: `rx_data` updated |

## Verification
The master sends all-zero, all-one, single-bit and mixed bytes so that bit order, bit polarity and stuck shift stages are told apart on both directions. Sessions are run with the ready input low throughout, rising in the middle of a byte, and already high at select, which separates busy-only, busy-then-idle and idle-first sequencing and shows that data never precedes the idle code. A session cut after three bits followed by a fresh session distinguishes a true clear of shift state from a carried-over fragment, and a 600-clock SCLK pause mid-byte separates clock-edge driven shifting from any hidden timeout.

// File: rtl/spi_sts_pkg.sv
package spi_sts_pkg;
  typedef enum logic {
    PH_STATUS = 1'b0,
    PH_DATA   = 1'b1
  } sts_phase_e;
endpackage

// File: rtl/spi_sts_sync.sv
module spi_sts_sync #(
  parameter int           WIDTH   = 3,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sts_rx.sv
module spi_sts_rx #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              byte_done,
  output logic              mid_byte
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;

  assign byte_done = bit_stb && (cnt == LAST);
  assign mid_byte  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (clear) begin
      cnt      <= '0;
      sh       <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (bit_stb) begin
        sh <= {sh[BYTE_W-2:0], bit_in};
        if (cnt == LAST) begin
          cnt      <= '0;
          rx_data  <= {sh[BYTE_W-2:0], bit_in};
          rx_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sts_tx.sv
module spi_sts_tx
  import spi_sts_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] BUSY_CODE = 8'hA5,
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deselect,
  input  logic              start,
  input  logic              byte_end,
  input  logic              shift_stb,
  input  logic              app_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_take,
  output logic              miso_bit
);
  sts_phase_e        phase, cur_phase;
  logic [BYTE_W-1:0] sh;

  assign cur_phase = start ? PH_STATUS : phase;
  assign miso_bit  = sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      phase   <= PH_STATUS;
      tx_take <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      if (deselect) begin
        sh    <= '0;
        phase <= PH_STATUS;
      end else if (start || byte_end) begin
        if (cur_phase == PH_DATA) begin
          sh      <= tx_data;
          tx_take <= 1'b1;
        end else if (app_ready) begin
          sh    <= IDLE_CODE;
          phase <= PH_DATA;
        end else begin
          sh    <= BUSY_CODE;
          phase <= PH_STATUS;
        end
      end else if (shift_stb) begin
        sh <= {sh[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_sts_slave.sv
module spi_sts_slave #(
  parameter int                BYTE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] BUSY_CODE   = 8'hA5,
  parameter logic [BYTE_W-1:0] IDLE_CODE   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso_d,
  output logic              spi_miso_oe,
  input  logic              app_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_take,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

  // R4: status codes must differ from a floating-high line
  if (BUSY_CODE == ALL_ONES || IDLE_CODE == ALL_ONES) begin : g_bad_code
    $error("status codes must not be all ones");
  end

  logic cs_s, sclk_s, mosi_s;
  logic cs_q, sclk_q;
  logic rise, fall, start;
  logic byte_done, mid_byte;

  spi_sts_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q({cs_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else begin
      cs_q        <= cs_s;
      sclk_q      <= sclk_s;
      spi_miso_oe <= ~cs_s;
    end
  end

  assign rise  = sclk_s & ~sclk_q & ~cs_s;
  assign fall  = ~sclk_s & sclk_q & ~cs_s;
  assign start = cs_q & ~cs_s;

  spi_sts_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .clear(cs_s),
    .bit_stb(rise), .bit_in(mosi_s),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .byte_done(byte_done), .mid_byte(mid_byte)
  );

  spi_sts_tx #(
    .BYTE_W(BYTE_W), .BUSY_CODE(BUSY_CODE), .IDLE_CODE(IDLE_CODE)
  ) u_tx (
    .clk(clk), .rst(rst), .deselect(cs_s), .start(start),
    .byte_end(byte_done), .shift_stb(fall & mid_byte),
    .app_ready(app_ready), .tx_data(tx_data),
    .tx_take(tx_take), .miso_bit(spi_miso_d)
  );
endmodule

// File: rtl/spi_sts_slave_chk.sv
module spi_sts_slave_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso_d,
  input logic spi_miso_oe,
  input logic rx_valid,
  input logic tx_take
);
  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  // R1
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso_oe);

  // R1
  select_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && !spi_cs_n && !$past(spi_cs_n) && !$past(spi_cs_n, 2) && !$past(spi_cs_n, 3))
      |-> spi_miso_oe);

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_take);

  // R7
  rx_in_session_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> spi_miso_oe);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && !spi_miso_oe && !$past(spi_miso_oe)) |-> !spi_miso_d);
endmodule

bind spi_sts_slave spi_sts_slave_chk u_chk (.*);

// File: tb/spi_sts_slave_tb.sv
module spi_sts_slave_tb;
  localparam int HALF = 8;
  localparam logic [7:0] BUSY = 8'hA5;
  localparam logic [7:0] IDLE = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso_d, spi_miso_oe, tx_take, rx_valid;
  logic app_ready = 1'b0;
  logic [7:0] tx_data, rx_data;

  logic [7:0] txq [16];
  int tx_idx = 0;
  assign tx_data = txq[tx_idx[3:0]];

  int checks = 0, fails = 0, cyc = 0, cs_stable = 0, rx_pulses = 0;
  logic [7:0] last_rx = '0;
  bit done = 0;

  bit m_data = 0;
  int m_idx = 0;
  logic [7:0] exp_cur;
  string exp_tag;

  always #5 clk = ~clk;

  spi_sts_slave u_dut (.*);

  always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // every-clock reference comparison of the pad enable and idle data (R1, R10)
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (rst) cs_stable <= 0;
    else begin
      cs_stable <= (spi_cs_n == cs_prev) ? cs_stable + 1 : 0;
      if (spi_cs_n == cs_prev && cs_stable >= 5) begin
        chk(spi_miso_oe == !spi_cs_n, "R1", "miso_oe", spi_miso_oe, !spi_cs_n);
        if (spi_cs_n) chk(spi_miso_d == 1'b0, "R10", "miso_d deselected", spi_miso_d, 0);
      end
    end
    cs_prev <= spi_cs_n;
    if (!rst && rx_valid) begin
      rx_pulses <= rx_pulses + 1;
      last_rx   <= rx_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic calc_next();
    if (m_data) begin
      exp_cur = txq[m_idx[3:0]]; m_idx++; exp_tag = "R5 data";
    end else if (app_ready) begin
      exp_cur = IDLE; m_data = 1; exp_tag = "R5 idle";
    end else begin
      exp_cur = BUSY; exp_tag = "R4 busy";
    end
  endtask

  task automatic start_session();
    spi_cs_n = 1'b0;
    m_data = 0;   // R6: status phase at each session start
    calc_next();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_session();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic xfer_byte(input logic [7:0] out, input int chg_bit,
                           input logic chg_val, input int pause_bit);
    logic [7:0] got = '0;
    int pre = rx_pulses;
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = out[i];
      if (i == pause_bit) repeat (600) @(negedge clk);
      if (i == chg_bit) app_ready = chg_val;
      repeat (HALF) @(negedge clk);
      got[i] = spi_miso_d;
      spi_sclk = 1'b1;
      if (i != 0) begin
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
    // R3: byte shifted out MSB first, first bit ready before first rise
    chk(got == exp_cur, "R3", exp_tag, got, exp_cur);
    calc_next();
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
    // R2: one pulse per byte with the received value
    chk(rx_pulses == pre + 1, "R2", "rx_valid count", rx_pulses - pre, 1);
    chk(last_rx == out, "R2", "rx_data", last_rx, out);
  endtask

  task automatic partial_abort(input logic [7:0] out, input int nbits);
    int pre = rx_pulses;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = out[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    end_session();
    // R7: aborted byte never delivered
    chk(rx_pulses == pre, "R7", "rx_valid on abort", rx_pulses - pre, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) txq[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R9
    chk(spi_miso_oe == 0, "R9", "oe after reset", spi_miso_oe, 0);
    chk(spi_miso_d == 0, "R9", "miso_d after reset", spi_miso_d, 0);
    chk(rx_valid == 0, "R9", "rx_valid after reset", rx_valid, 0);
    chk(tx_take == 0, "R9", "tx_take after reset", tx_take, 0);
    repeat (10) @(negedge clk);

    // not ready throughout: busy codes (R4)
    start_session();
    xfer_byte(8'h00, -1, 1'b0, -1);
    xfer_byte(8'hFF, -1, 1'b0, -1);
    // ready rises mid-byte: busy, then idle once, then data (R5)
    xfer_byte(8'h80, 4, 1'b1, -1);
    xfer_byte(8'h01, -1, 1'b0, -1);
    xfer_byte(8'h3C, -1, 1'b0, -1);
    xfer_byte(8'hC3, -1, 1'b0, -1);
    end_session();
    chk(tx_idx == m_idx, "R5", "tx_take count", tx_idx, m_idx);

    // ready already high: new session restarts with idle code (R6)
    start_session();
    chk(exp_cur == IDLE, "R6", "model first byte", exp_cur, IDLE);
    xfer_byte(8'h96, -1, 1'b0, -1);
    xfer_byte(8'h69, -1, 1'b0, -1);
    end_session();

    // abort mid data byte, then fresh session must be aligned (R7)
    start_session();
    xfer_byte(8'h12, -1, 1'b0, -1);
    partial_abort(8'hE7, 3);
    chk(spi_miso_oe == 0, "R7", "oe after abort", spi_miso_oe, 0);
    start_session();
    xfer_byte(8'h4D, -1, 1'b0, -1);
    xfer_byte(8'hB2, -1, 1'b0, -1);
    end_session();

    // long SCLK pause inside a byte (R8)
    start_session();
    xfer_byte(8'hA0, -1, 1'b0, 5);
    xfer_byte(8'h0F, -1, 1'b0, 2);
    end_session();
    chk(tx_idx == m_idx, "R8", "tx_take count", tx_idx, m_idx);

    // ready dropped: busy again after status restart (R4, R6)
    app_ready = 1'b0;
    repeat (4) @(negedge clk);
    start_session();
    xfer_byte(8'h55, -1, 1'b0, -1);
    end_session();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule